// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a synthesizable behavioural model of a single-ported synchronous RAM, meant to sit beside a processor and a cache controller. It stores 36-bit words, each made of four 9-bit lanes (8 data bits plus a parity bit). Every control and data input is sampled on the rising clock edge. Reads are flow-through: the word at the address captured on an edge is presented combinationally during the following cycle, with no output register. A four-beat burst therefore completes in a 2-1-1-1 pattern.

A burst begins when either the processor strobe or the controller strobe is asserted. That edge captures the address and the chip-select state. Later beats take their two low address bits from an internal 2-bit step counter. The counter moves only on edges where the advance input is high and neither strobe is high. A static mode pin chooses between a linear wrap order and an XOR-based interleaved order. Writes are split by lane under a write-all input or a byte-write input qualified by per-lane enables.

The shared data bus is presented in the form a pad ring expects: `data_i`, `data_o` and a drive enable `data_en`. It is a plain SRAM pin interface. It has no valid/ready handshake and no back-pressure: every beat completes in its own cycle.

Top module: `fs_burst_sram`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `data_en` is 0 and the device is deselected.
- R2: On an edge where `cpu_ads` or `ctl_ads` is 1, `addr` and the select state are captured. The device is selected only if `sel0_n`=0, `sel1`=1 and `sel2_n`=0 on that edge.
- R3: The step counter increments on an edge only if `adv`=1 and both strobes are 0. With `adv`=0 and no strobe, the access address holds.
- R4: With `burst_mode`=0, beat n of a burst (n = 0..3) uses low address bits (start + n) mod 4.
- R5: With `burst_mode`=1, beat n uses low address bits start XOR n.
- R6: Read data for the address set on an edge appears on `data_o` during the following cycle, before the next edge.
- R7: If both strobes are high, `cpu_ads` takes precedence. An edge with `cpu_ads`=1 is a read and writes nothing, whatever the write inputs are.
- R8: Lane k occupies `data_i`/`data_o` bits [9k+8:9k], with bit 9k+8 as parity. `wr_all`=1 writes all four lanes. Otherwise `wr_byte`=1 writes the lanes whose `lane_en[k]`=1. A written lane takes `data_i` on the same edge, at the address that edge sets.
- R9: While deselected, `data_en` is 0 and no lane is written, including during advance beats. This lasts until a strobe captures an active select.
- R10: `data_en` = `oe` AND (selected, and the last edge was a read). `oe` acts without a clock.
- R11: In the cycle after an edge that wrote at least one lane, `data_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | ADDR_W | Word address, captured on a strobe |
| cpu_ads | input | 1 | Processor address strobe, active high |
| ctl_ads | input | 1 | Controller address strobe, active high |
| adv | input | 1 | Burst advance |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| wr_all | input | 1 | Write all lanes |
| wr_byte | input | 1 | Write the lanes picked by lane_en |
| lane_en | input | LANES | Per-lane write enables |
| oe | input | 1 | Asynchronous output enable |
| burst_mode | input | 1 | 0 linear, 1 interleaved |
| data_i | input | LANES*LANE_BITS | Write data from the pad |
| data_o | output | LANES*LANE_BITS | Read data to the pad |
| data_en | output | 1 | Pad drive enable |

## Verification
The assertions check on every cycle that the counter steps only on a plain advance edge and holds otherwise. They also check that a strobe loads the pin address, that a processor strobe with an active select yields a read, and that a deselected device stays off the bus. The bench's scenarios show the remaining behaviour. These are the two burst orders with their exact sequences, flow-through timing of the first beat, lane-level write merging with parity, precedence when both strobes come together, and writes blocked while deselected. A reference model, fed by long random mixes of strobes, advances, selects and write enables, tracks every word.

// File: rtl/fsb_pkg.sv
package fsb_pkg;
  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } burst_order_e;

  // low address bits of beat n for a burst that began at first
  function automatic logic [1:0] burst_low(input logic [1:0] first,
                                           input logic [1:0] n,
                                           input logic mode);
    if (burst_order_e'(mode) == ORDER_INTERLEAVE) return first ^ n;
    return first + n;
  endfunction
endpackage

// File: rtl/fsb_addr_ctrl.sv
module fsb_addr_ctrl #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              load,
  input  logic              ce_ok,
  input  logic              adv,
  input  logic              mode,
  output logic [ADDR_W-1:0] next_addr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              next_sel,
  output logic              sel_q,
  output logic [1:0]        cnt_q
);
  import fsb_pkg::*;
  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] hi_q, next_hi;
  logic [1:0]      first_q, next_first, next_cnt;

  always_comb begin
    next_hi    = load ? addr[ADDR_W-1:2] : hi_q;
    next_first = load ? addr[1:0] : first_q;
    next_sel   = load ? ce_ok : sel_q;
    if (load)     next_cnt = 2'd0;
    else if (adv) next_cnt = cnt_q + 2'd1;
    else          next_cnt = cnt_q;
  end

  assign next_addr = {next_hi, burst_low(next_first, next_cnt, mode)};
  assign cur_addr  = {hi_q, burst_low(first_q, cnt_q, mode)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= '0;
      first_q <= '0;
      cnt_q   <= '0;
      sel_q   <= 1'b0;
    end else begin
      hi_q    <= next_hi;
      first_q <= next_first;
      cnt_q   <= next_cnt;
      sel_q   <= next_sel;
    end
  end
endmodule

// File: rtl/fsb_lane_decode.sv
module fsb_lane_decode #(
  parameter int LANES = 4
) (
  input  logic             wr_all,
  input  logic             wr_byte,
  input  logic [LANES-1:0] lane_en,
  input  logic             allow,
  output logic [LANES-1:0] mask
);
  always_comb begin
    if (!allow)       mask = '0;
    else if (wr_all)  mask = '1;
    else if (wr_byte) mask = lane_en;
    else              mask = '0;
  end
endmodule

// File: rtl/fsb_lane_array.sv
module fsb_lane_array #(
  parameter int ADDR_W    = 6,
  parameter int LANES     = 4,
  parameter int LANE_BITS = 9
) (
  input  logic                       clk,
  input  logic [LANES-1:0]           we_mask,
  input  logic [ADDR_W-1:0]          waddr,
  input  logic [LANES*LANE_BITS-1:0] wdata,
  input  logic [ADDR_W-1:0]          raddr,
  output logic [LANES*LANE_BITS-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_BITS-1:0] store [DEPTH];
    always_ff @(posedge clk) begin
      if (we_mask[g]) store[waddr] <= wdata[g*LANE_BITS +: LANE_BITS];
    end
    assign rdata[g*LANE_BITS +: LANE_BITS] = store[raddr];
  end
endmodule

// File: rtl/fs_burst_sram.sv
module fs_burst_sram #(
  parameter int ADDR_W    = 6,
  parameter int LANES     = 4,
  parameter int LANE_BITS = 9
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       cpu_ads,
  input  logic                       ctl_ads,
  input  logic                       adv,
  input  logic                       sel0_n,
  input  logic                       sel1,
  input  logic                       sel2_n,
  input  logic                       wr_all,
  input  logic                       wr_byte,
  input  logic [LANES-1:0]           lane_en,
  input  logic                       oe,
  input  logic                       burst_mode,
  input  logic [LANES*LANE_BITS-1:0] data_i,
  output logic [LANES*LANE_BITS-1:0] data_o,
  output logic                       data_en
);
  logic              ce_ok, load, allow, rd_q, next_sel, sel_q;
  logic [1:0]        cnt_q;
  logic [LANES-1:0]  we_mask;
  logic [ADDR_W-1:0] next_addr, cur_addr;

  assign ce_ok = !sel0_n && sel1 && !sel2_n;
  assign load  = cpu_ads || ctl_ads;
  // a processor strobe edge is always a read
  assign allow = next_sel && !cpu_ads;

  fsb_addr_ctrl #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .addr(addr), .load(load), .ce_ok(ce_ok),
    .adv(adv), .mode(burst_mode), .next_addr(next_addr),
    .cur_addr(cur_addr), .next_sel(next_sel), .sel_q(sel_q), .cnt_q(cnt_q)
  );

  fsb_lane_decode #(.LANES(LANES)) u_dec (
    .wr_all(wr_all), .wr_byte(wr_byte), .lane_en(lane_en),
    .allow(allow), .mask(we_mask)
  );

  fsb_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_BITS(LANE_BITS)) u_mem (
    .clk(clk), .we_mask(we_mask), .waddr(next_addr), .wdata(data_i),
    .raddr(cur_addr), .rdata(data_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= 1'b0;
    else        rd_q <= ~|we_mask;
  end

  assign data_en = oe && sel_q && rd_q;
endmodule

// File: rtl/fsb_checker.sv
module fsb_checker #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_ads,
  input logic              ctl_ads,
  input logic              adv,
  input logic              ce_ok,
  input logic [ADDR_W-1:0] addr,
  input logic [1:0]        cnt_q,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              rd_q,
  input logic              sel_q,
  input logic              data_en
);
  // R3
  step_on_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !cpu_ads && !ctl_ads) |=> cnt_q == 2'($past(cnt_q) + 2'd1));
  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !cpu_ads && !ctl_ads) |=> ($stable(cnt_q) && $stable(cur_addr)));
  // R2
  strobe_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ads || ctl_ads) |=> (cur_addr == $past(addr) && cnt_q == 2'd0));
  // R7
  cpu_strobe_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ads && ce_ok) |=> rd_q);
  // R9
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cpu_ads || ctl_ads) && !ce_ok) |=> !data_en);
  // R9
  deselect_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_q && !cpu_ads && !ctl_ads) |=> !data_en);
endmodule

bind fs_burst_sram fsb_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_ads(cpu_ads), .ctl_ads(ctl_ads), .adv(adv),
  .ce_ok(ce_ok), .addr(addr), .cnt_q(cnt_q), .cur_addr(cur_addr),
  .rd_q(rd_q), .sel_q(sel_q), .data_en(data_en)
);

// File: tb/sim_fs_burst_sram.sv
module sim_fs_burst_sram;
  localparam int AW = 6;
  localparam int LN = 4;
  localparam int LB = 9;
  localparam int WW = LN * LB;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic cpu_ads = 0, ctl_ads = 0, adv = 0, sel0_n = 0, sel1 = 1, sel2_n = 0;
  logic wr_all = 0, wr_byte = 0, oe = 1, burst_mode = 0;
  logic [LN-1:0] lane_en = '0;
  logic [WW-1:0] data_i = '0, data_o;
  logic data_en;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  logic [WW-1:0] mem_m [DEPTH];
  logic [AW-3:0] m_hi = '0;
  logic [1:0] m_first = '0;
  int m_n = 0;
  bit m_sel = 0, m_rd = 0;

  always #10 clk = ~clk;

  fs_burst_sram #(.ADDR_W(AW), .LANES(LN), .LANE_BITS(LB)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cpu_ads(cpu_ads),
    .ctl_ads(ctl_ads), .adv(adv), .sel0_n(sel0_n), .sel1(sel1),
    .sel2_n(sel2_n), .wr_all(wr_all), .wr_byte(wr_byte), .lane_en(lane_en),
    .oe(oe), .burst_mode(burst_mode), .data_i(data_i), .data_o(data_o),
    .data_en(data_en)
  );

  function automatic logic [WW-1:0] pat(input int a);
    return WW'(a) * 36'h1_2345_6789 ^ 36'h9_0F0F_0F0F;
  endfunction

  function automatic int low_of(input int first, input int n, input bit mode);
    if (mode) return first ^ n;
    return (first + n) % 4;
  endfunction

  function automatic int m_addr();
    return int'(m_hi) * 4 + low_of(int'(m_first), m_n, burst_mode);
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_update();
    bit strobe, ce;
    logic [LN-1:0] m;
    strobe = cpu_ads || ctl_ads;
    ce = !sel0_n && sel1 && !sel2_n;
    if (!rst_n) begin
      m_sel = 0; m_rd = 0; m_n = 0; m_hi = '0; m_first = '0;
      return;
    end
    if (strobe) begin
      m_sel = ce; m_hi = addr[AW-1:2]; m_first = addr[1:0]; m_n = 0;
    end else if (adv) m_n = (m_n + 1) % 4;
    m = '0;
    if (m_sel && !cpu_ads) m = wr_all ? 4'hF : (wr_byte ? lane_en : 4'h0);
    for (int k = 0; k < LN; k++)
      if (m[k]) mem_m[m_addr()][k*LB +: LB] = data_i[k*LB +: LB];
    m_rd = (m == 0);
  endtask

  task automatic check_out(input string tag);
    bit exp_en;
    exp_en = oe && m_sel && m_rd;
    chk(data_en == exp_en, {tag, " R10 drive enable"}, WW'(data_en), WW'(exp_en));
    if (exp_en)
      chk(data_o == mem_m[m_addr()], {tag, " R6 read data"}, data_o, mem_m[m_addr()]);
  endtask

  task automatic cycle(input string tag);
    @(posedge clk);
    model_update();
    @(negedge clk);
    check_out(tag);
  endtask

  task automatic idle_in();
    cpu_ads = 0; ctl_ads = 0; adv = 0; wr_all = 0; wr_byte = 0; lane_en = '0;
    sel0_n = 0; sel1 = 1; sel2_n = 0; oe = 1;
  endtask

  // cpu-strobed burst read of 4 beats, compare against given addresses
  task automatic read_burst(input int a0, input int e0, input int e1,
                            input int e2, input int e3, input string tag);
    int ex[4];
    ex = '{e0, e1, e2, e3};
    idle_in(); addr = AW'(a0); cpu_ads = 1;
    for (int b = 0; b < 4; b++) begin
      cycle(tag);
      chk(data_en && data_o == mem_m[ex[b]], tag, data_o, mem_m[ex[b]]);
      cpu_ads = 0; adv = 1;
    end
    idle_in();
  endtask

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    // R1: reset state
    for (int i = 0; i < 3; i++) cycle("R1 in reset");
    chk(data_en == 0, "R1 reset data_en", WW'(data_en), '0);
    rst_n = 1;
    cycle("R1 after reset");
    chk(data_en == 0, "R1 first cycle after reset", WW'(data_en), '0);

    // fill the array with bursts, controller strobe, linear order (R8)
    for (int w = 0; w < DEPTH / 4; w++) begin
      idle_in(); addr = AW'(w * 4); ctl_ads = 1; wr_all = 1;
      for (int b = 0; b < 4; b++) begin
        data_i = pat(w * 4 + b);
        cycle("R8 fill");
        chk(data_en == 0, "R11 write cycle off bus", WW'(data_en), '0);
        ctl_ads = 0; adv = 1;
      end
    end
    idle_in();
    for (int a = 0; a < DEPTH; a++)
      chk(mem_m[a] == pat(a), "R8 fill contents", mem_m[a], pat(a));

    // R4 linear from start 1: 5,6,7,4 ; R6 first beat right after address edge
    burst_mode = 0;
    read_burst(5, 5, 6, 7, 4, "R4 linear order");
    // R5 interleaved from start 1: 5,4,7,6 and from start 2: 10,11,8,9
    burst_mode = 1;
    read_burst(5, 5, 4, 7, 6, "R5 interleaved order");
    read_burst(10, 10, 11, 8, 9, "R5 interleaved start 2");
    burst_mode = 0;

    // R3 hold: no adv, no strobe keeps the same word
    idle_in(); addr = AW'(13); cpu_ads = 1; cycle("R3 load");
    cpu_ads = 0;
    for (int i = 0; i < 3; i++) begin
      cycle("R3 hold");
      chk(data_o == pat(13), "R3 hold address", data_o, pat(13));
    end
    // R3 adv ignored on a strobe edge
    addr = AW'(20); cpu_ads = 1; adv = 1; cycle("R3 strobe beats adv");
    chk(data_o == pat(20), "R3 strobe with adv starts at beat 0", data_o, pat(20));
    idle_in();

    // R7 both strobes plus write: read, no write
    addr = AW'(7); cpu_ads = 1; ctl_ads = 1; wr_all = 1; data_i = '1;
    cycle("R7 both strobes");
    chk(data_en == 1 && data_o == pat(7), "R7 cpu strobe reads", data_o, pat(7));
    idle_in(); addr = AW'(7); cpu_ads = 1; cycle("R7 reread");
    chk(data_o == pat(7), "R7 word unchanged", data_o, pat(7));

    // R8 lane write, lanes 0 and 2 (bits 8:0 and 26:18, parity 8 and 26)
    idle_in(); addr = AW'(4); ctl_ads = 1; wr_byte = 1; lane_en = 4'b0101;
    data_i = '1; cycle("R8 lane write");
    idle_in(); addr = AW'(4); cpu_ads = 1; cycle("R8 lane readback");
    chk(data_o == (pat(4) | 36'h0_07FC_01FF), "R8 lane merge", data_o,
        pat(4) | 36'h0_07FC_01FF);
    // R8 wr_byte with no lanes and no wr_all writes nothing
    idle_in(); addr = AW'(9); ctl_ads = 1; wr_byte = 1; lane_en = '0; data_i = '0;
    cycle("R8 empty mask");
    chk(data_en == 1 && data_o == pat(9), "R8 empty mask is read", data_o, pat(9));

    // R9 deselected controller write, then advance writes: all blocked
    idle_in(); addr = AW'(24); ctl_ads = 1; sel1 = 0; wr_all = 1; data_i = '0;
    cycle("R9 deselect");
    chk(data_en == 0, "R9 deselect off bus", WW'(data_en), '0);
    ctl_ads = 0; sel1 = 1; adv = 1;
    for (int i = 0; i < 2; i++) begin
      cycle("R9 deselected adv");
      chk(data_en == 0, "R9 stays deselected", WW'(data_en), '0);
    end
    idle_in(); burst_mode = 0;
    read_burst(24, 24, 25, 26, 27, "R9 no write while deselected");
    // R2 each select pin alone deselects
    for (int s = 0; s < 3; s++) begin
      idle_in(); addr = AW'(30); cpu_ads = 1;
      if (s == 0) sel0_n = 1; else if (s == 1) sel1 = 0; else sel2_n = 1;
      cycle("R2 select");
      chk(data_en == 0, "R2 inactive select", WW'(data_en), '0);
    end

    // R10 oe acts without a clock
    idle_in(); addr = AW'(33); cpu_ads = 1; cycle("R10 load");
    cpu_ads = 0; oe = 0; #2;
    chk(data_en == 0, "R10 oe low async", WW'(data_en), '0);
    oe = 1; #2;
    chk(data_en == 1, "R10 oe high async", WW'(data_en), 36'd1);
    @(negedge clk);

    // random mix against the model
    for (int i = 0; i < 4000; i++) begin
      int r;
      if (i % 500 == 0) burst_mode = $urandom % 2;
      r = $urandom % 10;
      cpu_ads = (r < 2) || (r == 9);
      ctl_ads = (r == 2) || (r == 3) || (r == 9);
      adv = $urandom % 2;
      addr = AW'($urandom);
      sel0_n = ($urandom % 16) == 0; sel1 = ($urandom % 16) != 0;
      sel2_n = ($urandom % 16) == 0;
      wr_all = ($urandom % 5) == 0; wr_byte = ($urandom % 3) == 0;
      lane_en = LN'($urandom); oe = ($urandom % 8) != 0;
      data_i = {4'($urandom), 32'($urandom)};
      cycle("R4 R5 R8 random");
    end

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule